// File: doc/BRIEF.md
# Per-Channel Offset and Gain Corrector

This block sits on the sample path of a multi-channel converter and trims every raw 24-bit two's complement sample before it leaves. For the channel named alongside the sample, it first removes a programmable offset and then scales the difference by a programmable unsigned gain. The result is saturated to the 24-bit signed range. Every channel has its own offset and its own gain. After reset the block is transparent.

Software loads the coefficients through a small write port. Each 24-bit coefficient is split into a 16-bit upper word and an 8-bit lower word. Writing the upper word only parks it in a holding register. Writing the lower word commits the whole coefficient in one step, so a sample is never corrected with half of an old value and half of a new one. The datapath has two stages (subtract, then multiply and clamp) and a fixed latency of two clock cycles.

Top module: `chan_trim_corrector`

## Requirements
- R1: After reset, every offset is 0 and every gain is 0x800000 (unity). A sample then comes out unchanged, and `out_valid` is low until the first accepted sample.
- R2: A sample taken with `in_valid` high at a clock edge appears two rising edges later with `out_valid` high. `out_valid` is low in every other cycle.
- R3: The stored offset (24-bit two's complement) is subtracted from the sample. A difference above 0x7FFFFF becomes 0x7FFFFF, and one below 0x800000 becomes 0x800000.
- R4: The difference is multiplied by the gain, which is unsigned with 1 integer bit and 23 fraction bits (0 up to 2 minus 2^-23). The product is truncated toward minus infinity by dropping its 23 fraction bits. A gain of 0 gives 0.
- R5: A scaled value outside the 24-bit signed range is clamped to 0x7FFFFF (positive) or 0x800000 (negative).
- R6: Each channel uses only its own offset and gain. A write to one channel leaves the results of every other channel unchanged.
- R7: An upper-word write alone leaves the coefficient in use unchanged. The following lower-word write to the same coefficient commits {held upper word, lower byte} at once. A sample driven in the same cycle as a write uses the old coefficient.
- R8: The write address is {channel, select}, where select is the two LSBs: 0 is offset upper, 1 is offset lower, 2 is gain upper and 3 is gain lower. An upper write carries coefficient bits 23:8 in `wr_data[15:0]`. A lower write carries coefficient bits 7:0 in `wr_data[7:0]`. At reset the holding registers contain the reset coefficients' upper words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_chan | input | CHW | Channel index of the sample |
| in_sample | input | 24 | Raw signed sample |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | CHW+2 | {channel, select} |
| wr_data | input | 16 | Coefficient word |
| out_valid | output | 1 | Corrected sample present |
| out_sample | output | 24 | Corrected, saturated sample |

## Verification
The bench uses the default of four channels, so CHW is 2. Channel index and select are both two bits wide. This lets random traffic mix samples and lone upper-word writes across every channel and every select code. With only four channels, random addresses hit each coefficient often enough to produce many split-write sequences and saturations in both directions. Directed cases add the extreme offsets, a gain of zero, a gain of one half and the largest gain.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
    localparam int unsigned SMP_W  = 24;
    localparam int unsigned HI_W   = 16;
    localparam int unsigned LO_W   = SMP_W - HI_W;
    localparam int unsigned FRAC_W = SMP_W - 1;

    localparam logic [SMP_W-1:0] GAIN_ONE = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] POS_MAX  = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [SMP_W-1:0] NEG_MIN  = {1'b1, {(SMP_W-1){1'b0}}};

    typedef enum logic [1:0] {
        SEL_OFF_HI  = 2'd0,
        SEL_OFF_LO  = 2'd1,
        SEL_GAIN_HI = 2'd2,
        SEL_GAIN_LO = 2'd3
    } coef_sel_e;
endpackage

// File: rtl/cgc_coef_bank.sv
module cgc_coef_bank
    import cgc_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned CHW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CHW+1:0]        wr_addr,
    input  logic [HI_W-1:0]       wr_data,
    output logic [NCH*SMP_W-1:0]  off_tab,
    output logic [NCH*SMP_W-1:0]  gain_tab
);
    coef_sel_e sel;
    assign sel = coef_sel_e'(wr_addr[1:0]);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic             hit;
        logic [HI_W-1:0]  off_hold, gain_hold;
        logic [SMP_W-1:0] off_q, gain_q;

        assign hit = wr_en && (wr_addr[CHW+1:2] == CHW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_hold  <= '0;
                gain_hold <= GAIN_ONE[SMP_W-1:LO_W];
                off_q     <= '0;
                gain_q    <= GAIN_ONE;
            end else if (hit) begin
                unique case (sel)
                    SEL_OFF_HI:  off_hold  <= wr_data;
                    SEL_OFF_LO:  off_q     <= {off_hold, wr_data[LO_W-1:0]};
                    SEL_GAIN_HI: gain_hold <= wr_data;
                    SEL_GAIN_LO: gain_q    <= {gain_hold, wr_data[LO_W-1:0]};
                    default: ;
                endcase
            end
        end

        assign off_tab[g*SMP_W +: SMP_W]  = off_q;
        assign gain_tab[g*SMP_W +: SMP_W] = gain_q;
    end
endmodule

// File: rtl/cgc_sub_stage.sv
module cgc_sub_stage
    import cgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_sample,
    input  logic [SMP_W-1:0] off,
    input  logic [SMP_W-1:0] gain,
    output logic             s1_valid,
    output logic [SMP_W-1:0] s1_diff,
    output logic [SMP_W-1:0] s1_gain
);
    logic [SMP_W:0]   wide;
    logic [SMP_W-1:0] clamped;

    always_comb begin
        wide = {in_sample[SMP_W-1], in_sample} - {off[SMP_W-1], off};
        if (wide[SMP_W] != wide[SMP_W-1])
            clamped = wide[SMP_W] ? NEG_MIN : POS_MAX;
        else
            clamped = wide[SMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_diff  <= '0;
            s1_gain  <= GAIN_ONE;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_diff <= clamped;
                s1_gain <= gain;
            end
        end
    end
endmodule

// File: rtl/cgc_mul_stage.sv
module cgc_mul_stage
    import cgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic [SMP_W-1:0] s1_diff,
    input  logic [SMP_W-1:0] s1_gain,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_sample
);
    localparam int unsigned PW = 2 * SMP_W + 1;

    logic signed [PW-1:0] prod, shifted;
    logic [SMP_W-1:0]     clamped;
    logic                 fits;

    always_comb begin
        prod    = PW'($signed(s1_diff)) * $signed({{(SMP_W+1){1'b0}}, s1_gain});
        shifted = prod >>> FRAC_W;
        fits    = (shifted[PW-1:SMP_W-1] == '0) || (shifted[PW-1:SMP_W-1] == '1);
        if (fits)
            clamped = shifted[SMP_W-1:0];
        else
            clamped = shifted[PW-1] ? NEG_MIN : POS_MAX;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_sample <= clamped;
        end
    end
endmodule

// File: rtl/chan_trim_corrector.sv
module chan_trim_corrector
    import cgc_pkg::*;
#(
    parameter int unsigned NCH = 4,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CHW-1:0]   in_chan,
    input  logic [SMP_W-1:0] in_sample,
    input  logic             wr_en,
    input  logic [CHW+1:0]   wr_addr,
    input  logic [HI_W-1:0]  wr_data,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_sample
);
    logic [NCH*SMP_W-1:0] off_tab, gain_tab;
    logic [SMP_W-1:0]     cur_off, cur_gain;
    logic                 s1_valid;
    logic [SMP_W-1:0]     s1_diff, s1_gain;

    cgc_coef_bank #(.NCH(NCH), .CHW(CHW)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .off_tab(off_tab), .gain_tab(gain_tab)
    );

    assign cur_off  = off_tab[32'(in_chan) * SMP_W +: SMP_W];
    assign cur_gain = gain_tab[32'(in_chan) * SMP_W +: SMP_W];

    cgc_sub_stage sub_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .off(cur_off), .gain(cur_gain),
        .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_gain(s1_gain)
    );

    cgc_mul_stage mul_i (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_diff(s1_diff),
        .s1_gain(s1_gain), .out_valid(out_valid), .out_sample(out_sample)
    );
endmodule

// File: rtl/cgc_checker.sv
module cgc_checker
    import cgc_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 wr_en,
    input logic                 wr_sel_lsb,
    input logic                 s1_valid,
    input logic [SMP_W-1:0]     s1_diff,
    input logic [SMP_W-1:0]     s1_gain,
    input logic                 out_valid,
    input logic [SMP_W-1:0]     out_sample,
    input logic [NCH*SMP_W-1:0] off_tab,
    input logic [NCH*SMP_W-1:0] gain_tab
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    p_unity_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_gain == GAIN_ONE) |=> (out_sample == $past(s1_diff)));

    p_zero_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_gain == '0) |=> (out_sample == '0));

    p_upper_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel_lsb) |=> ($stable(off_tab) && $stable(gain_tab)));
endmodule

bind chan_trim_corrector cgc_checker #(.NCH(NCH)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wr_en(wr_en),
    .wr_sel_lsb(wr_addr[0]), .s1_valid(s1_valid), .s1_diff(s1_diff),
    .s1_gain(s1_gain), .out_valid(out_valid), .out_sample(out_sample),
    .off_tab(off_tab), .gain_tab(gain_tab)
);

// File: tb/chan_trim_corrector_tb_top.sv
module chan_trim_corrector_tb_top;
    localparam int PERIOD = 10;
    localparam int NCH    = 4;
    localparam int CHW    = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [CHW-1:0]  in_chan = '0;
    logic [23:0]     in_sample = '0;
    logic            wr_en = 1'b0;
    logic [CHW+1:0]  wr_addr = '0;
    logic [15:0]     wr_data = '0;
    logic            out_valid;
    logic [23:0]     out_sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] m_off [NCH];
    logic [23:0] m_gain[NCH];
    logic [15:0] m_ohold[NCH];
    logic [15:0] m_ghold[NCH];

    bit          ev [2];
    logic [23:0] es [2];
    string       et [2];

    always #(PERIOD/2) clk = ~clk;

    chan_trim_corrector #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic logic [23:0] ref_corr(logic [23:0] s, logic [23:0] o, logic [23:0] g);
        longint d, p;
        d = longint'($signed(s)) - longint'($signed(o));
        if (d > 64'sd8388607)  d = 64'sd8388607;
        if (d < -64'sd8388608) d = -64'sd8388608;
        p = d * longint'({40'd0, g});
        p = p >>> 23;
        if (p > 64'sd8388607)  p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return p[23:0];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One cycle: check output due now, then drive new stimulus.
    task automatic cyc(bit v, int ch, logic [23:0] s, bit we, logic [3:0] a,
                       logic [15:0] d, string tag);
        int wc;
        @(negedge clk);
        check({"R2 valid ", et[1]}, {31'd0, out_valid}, {31'd0, ev[1]});
        if (ev[1]) check(et[1], {8'd0, out_sample}, {8'd0, es[1]});
        ev[1] = ev[0]; es[1] = es[0]; et[1] = et[0];
        ev[0] = v;
        es[0] = ref_corr(s, m_off[ch], m_gain[ch]);
        et[0] = tag;
        in_valid = v; in_chan = CHW'(ch); in_sample = s;
        wr_en = we; wr_addr = a; wr_data = d;
        if (we) begin
            wc = int'(a[3:2]);
            case (a[1:0])
                2'd0: m_ohold[wc] = d;
                2'd1: m_off[wc]   = {m_ohold[wc], d[7:0]};
                2'd2: m_ghold[wc] = d;
                default: m_gain[wc] = {m_ghold[wc], d[7:0]};
            endcase
        end
    endtask

    task automatic wr_coef(int ch, bit is_gain, logic [23:0] v);
        cyc(0, 0, 0, 1, {2'(ch), is_gain, 1'b0}, v[23:8], "R8 wr");
        cyc(0, 0, 0, 1, {2'(ch), is_gain, 1'b1}, {8'd0, v[7:0]}, "R8 wr");
    endtask

    task automatic smp(int ch, logic [23:0] s, string tag);
        cyc(1, ch, s, 0, 0, 0, tag);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCH; i++) begin
            m_off[i] = 0; m_gain[i] = 24'h800000;
            m_ohold[i] = 0; m_ghold[i] = 16'h8000;
        end
        for (int i = 0; i < 2; i++) begin ev[i] = 0; es[i] = 0; et[i] = "idle"; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset data", {8'd0, out_sample}, 32'd0);

        // R1: transparent after reset
        smp(0, 24'h123456, "R1 pass");
        smp(3, 24'h800000, "R1 pass min");
        smp(2, 24'h7FFFFF, "R1 pass max");
        cyc(0, 0, 0, 0, 0, 0, "R2 gap");
        smp(1, 24'hFFFFFF, "R1 pass -1");

        // R3: offset subtraction and its saturation
        wr_coef(0, 0, 24'h000001);
        smp(0, 24'h800000, "R3 sub neg sat");
        smp(0, 24'h000010, "R3 sub");
        wr_coef(1, 0, 24'hFFFFFF);
        smp(1, 24'h7FFFFF, "R3 sub pos sat");
        smp(1, 24'h000010, "R3 sub neg off");

        // R4: gain scaling and floor truncation
        wr_coef(2, 1, 24'h400000);
        smp(2, 24'hFFFFFD, "R4 half floor");
        smp(2, 24'h000003, "R4 half pos");
        wr_coef(3, 1, 24'h000000);
        smp(3, 24'h7FFFFF, "R4 zero gain");

        // R5: product saturation
        wr_coef(2, 1, 24'hFFFFFF);
        smp(2, 24'h7FFFFF, "R5 pos sat");
        smp(2, 24'h800000, "R5 neg sat");
        smp(2, 24'h000100, "R5 in range");

        // R7: upper word parked until lower word
        cyc(0, 0, 0, 1, 4'b0110, 16'h4000, "R7 hi only");
        smp(1, 24'h000100, "R7 old gain");
        cyc(1, 1, 24'h000100, 1, 4'b0111, 16'h0000, "R7 same cycle old");
        smp(1, 24'h000100, "R7 committed");

        // R6: other channels untouched by the writes above
        smp(0, 24'h000010, "R6 ch0 own");
        smp(1, 24'h000100, "R6 ch1 own");

        // Random mixed traffic across channels and selects (R6 R7 R8)
        for (int n = 0; n < 3000; n++) begin
            bit v, we;
            v  = ($urandom % 4) != 0;
            we = ($urandom % 5) == 0;
            cyc(v, int'($urandom % NCH), 24'($urandom), we, 4'($urandom),
                16'($urandom), "R6 random");
        end
        repeat (3) cyc(0, 0, 0, 0, 0, 0, "R2 drain");
        finish_run();
    end
endmodule